// File: doc/BRIEF.md
# Chip Erase Sequencer

This block wipes every piece of device state in a fixed order when software asks it to. Software reaches it through a simple register port with a write strobe, an address, write data and combinational read data. Writing a one to the start bit of the command register launches the erase. The sequencer then works through three phases in a strict order: the volatile memories first, the main flash array second, and the protection state last. For each phase it sends a request to an external clear agent and waits for that agent's acknowledge. The memories and flash cells sit outside the block, behind these handshake ports.

A status register shows whether an erase is running and whether one has finished, and software polls it. The flash phase sends a region mask with its request, and the mask always keeps the reserved user page out of the erase. The block also holds the device protection flag. Software may arm a pending protection value at any time, but it only reaches the active flag on the next functional reset. A completed erase clears both the pending and the active value. Once an erase has started, the functional-enable output stays low until a reset restarts the device. A separate power-on reset clears the modelled nonvolatile protection state as well.

Top module: `chip_erase_seq`

## Requirements
- R1: A bus write to address 0 with data bit 0 set, made while no erase is running, starts an erase. The busy bit (status address 1, bit 0) reads 1 in the cycle after that write, and `clr_req[0]` is high in that same cycle.
- R2: The phases run in index order 0 (volatile), 1 (flash), 2 (protection). Each request is high for exactly one cycle. The sequencer then waits any number of cycles for `clr_ack` at the same index. The next phase's request is high in the cycle after that acknowledge is sampled.
- R3: While `clr_req[1]` is high, `flash_mask` has every region bit set except bit USER_PAGE_IDX. At all other times `flash_mask` is zero.
- R4: Busy stays high until the protection phase's acknowledge is sampled. From the next cycle busy reads 0 and done (status bit 1) reads 1. Done is cleared in the cycle after the next accepted start, and by either reset.
- R5: A start write made while busy has no effect: no extra request follows it and the phase in progress continues. Bit 0 of address 0 always reads 0.
- R6: Writing data bit 1 to address 0 sets the pending protection value. It reads back at address 0 bit 1 and at status bit 3. `prot_active` (also status bit 2) keeps its value until the next `rst_n` edge, where it takes on the pending value.
- R7: When an erase finishes, the pending and active protection values are both cleared, in the same cycle that done rises.
- R8: `func_en` is 1 after a reset. It goes to 0 in the cycle after an accepted start and stays 0 until the next reset.
- R9: A power-on reset (`por_n` low) clears the sequencer, done, `func_en`'s latch and both protection values. After it, the status register reads 0.
- R10: An acknowledge has an effect only when it arrives at the index of the phase being waited on. An acknowledge sampled while a request is high, or at another index, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low functional reset; loads pending protection into active |
| por_n | input | 1 | Synchronous active-low power-on reset; also clears protection state |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 command, 1 status) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr, combinational |
| clr_req | output | 3 | One-cycle clear request per phase |
| clr_ack | input | 3 | Clear acknowledge per phase |
| flash_mask | output | NUM_REGIONS | Flash regions to clear, valid with clr_req[1] |
| prot_active | output | 1 | Active device protection flag |
| func_en | output | 1 | Normal operation allowed |

## Verification
Every result appears one clock after the edge that samples its cause. The status bits, `func_en` and the next request all change in the cycle after a start write or an acknowledge. The active protection value changes in the cycle after a reset edge. The bench drives inputs and samples outputs on the falling edge. After each stimulus it waits exactly one falling edge before it checks, so each check lands in the first cycle in which the new value is due. Across a sweep of acknowledge delays of 0 to 2 cycles in every phase, the bench also checks that each request is absent during the whole wait.

// File: rtl/ces_pkg.sv
// Package: shared constants for the chip erase sequencer.
// Assumes the register map and phase count below are fixed for all users.
package ces_pkg;
    localparam int NUM_PHASES  = 3;             // volatile, flash, protection
    localparam int PH_IDX_W    = $clog2(NUM_PHASES);
    localparam int PH_VOL      = 0;
    localparam int PH_FLASH    = 1;
    localparam int PH_PROT     = 2;
    localparam int CMD_ADDR    = 0;             // command register
    localparam int STAT_ADDR   = 1;             // status register
    localparam int CMD_START   = 0;             // command bit: start erase
    localparam int CMD_PROT    = 1;             // command bit: arm protection
    localparam int ST_BUSY     = 0;
    localparam int ST_DONE     = 1;
    localparam int ST_PACT     = 2;
    localparam int ST_PPEND    = 3;
endpackage

// File: rtl/ces_phase_fsm.sv
// Module: ces_phase_fsm
// Steps through the erase phases in index order. Each phase raises its request
// for one cycle and then waits for the acknowledge at its own index.
// Assumes start_i is only pulsed while busy_o is low (the register block gates it).
module ces_phase_fsm
    import ces_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_n,
    input  logic                  start_i,
    input  logic [NUM_PHASES-1:0] ack_i,
    output logic [NUM_PHASES-1:0] req_o,
    output logic                  busy_o,
    output logic                  fin_o
);
    localparam logic [PH_IDX_W-1:0] LAST_IDX = PH_IDX_W'(NUM_PHASES - 1);

    logic                busy_q;
    logic                wait_q;
    logic [PH_IDX_W-1:0] idx_q;
    logic                ack_hit;

    // Acknowledge that counts: right index, while waiting.
    always_comb begin
        ack_hit = busy_q && wait_q && ack_i[idx_q];
        fin_o   = ack_hit && (idx_q == LAST_IDX);
        busy_o  = busy_q;
    end

    // Phase state: start, move from request to wait, advance on a matching acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            busy_q <= 1'b0;
            wait_q <= 1'b0;
            idx_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            wait_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q && !wait_q) begin
            wait_q <= 1'b1;
        end else if (ack_hit) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
                wait_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + 1'b1;
                wait_q <= 1'b0;
            end
        end
    end

    // One request line per phase, high only in that phase's request cycle.
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_req
        assign req_o[p] = busy_q && !wait_q && (idx_q == PH_IDX_W'(p));
    end
endmodule

// File: rtl/ces_flash_mask.sv
// Module: ces_flash_mask
// Builds the region mask sent with the flash clear request. The reserved
// user page region is never selected.
// Assumes USER_PAGE_IDX < NUM_REGIONS.
module ces_flash_mask #(
    parameter int NUM_REGIONS   = 4,
    parameter int USER_PAGE_IDX = 3
) (
    input  logic                   en_i,
    output logic [NUM_REGIONS-1:0] mask_o
);
    // One bit per region; the user page bit is tied low.
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        if (r == USER_PAGE_IDX) begin : g_keep
            assign mask_o[r] = 1'b0;
        end else begin : g_clr
            assign mask_o[r] = en_i;
        end
    end
endmodule

// File: rtl/ces_regs.sv
// Module: ces_regs
// Register front end: decodes the command and status registers, holds
// done, the functional enable latch and the pending/active protection values.
// Assumes a single-cycle write strobe and combinational reads.
module ces_regs
    import ces_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy_i,
    input  logic              fin_i,
    output logic              start_o,
    output logic              prot_active_o,
    output logic              func_en_o
);
    logic done_q;
    logic func_en_q;
    logic prot_pend_q;
    logic prot_act_q;
    logic cmd_wr;

    // Command decode; a start is accepted only while idle.
    always_comb begin
        cmd_wr  = bus_wr && (bus_addr == ADDR_W'(CMD_ADDR));
        start_o = cmd_wr && bus_wdata[CMD_START] && !busy_i;
    end

    // Done flag and functional enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            done_q    <= 1'b0;
            func_en_q <= 1'b1;
        end else begin
            if (start_o)    done_q <= 1'b0;
            else if (fin_i) done_q <= 1'b1;
            if (start_o)    func_en_q <= 1'b0;
        end
    end

    // Protection values: power-on clears, reset promotes pending, erase clears both.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            prot_pend_q <= 1'b0;
            prot_act_q  <= 1'b0;
        end else if (!rst_n) begin
            prot_act_q  <= prot_pend_q;
        end else if (fin_i) begin
            prot_pend_q <= 1'b0;
            prot_act_q  <= 1'b0;
        end else if (cmd_wr && bus_wdata[CMD_PROT]) begin
            prot_pend_q <= 1'b1;
        end
    end

    // Read mux over the two registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CMD_ADDR)) begin
            bus_rdata[CMD_PROT] = prot_pend_q;
        end else if (bus_addr == ADDR_W'(STAT_ADDR)) begin
            bus_rdata[ST_BUSY]  = busy_i;
            bus_rdata[ST_DONE]  = done_q;
            bus_rdata[ST_PACT]  = prot_act_q;
            bus_rdata[ST_PPEND] = prot_pend_q;
        end
    end

    assign prot_active_o = prot_act_q;
    assign func_en_o     = func_en_q;
endmodule

// File: rtl/chip_erase_seq.sv
// Module: chip_erase_seq (top)
// Chip erase sequencer: register front end, phase sequencer and flash
// region mask. Clears volatile memory, flash and protection in that order.
// Assumes clear agents acknowledge no earlier than the cycle after a request.
module chip_erase_seq
    import ces_pkg::*;
#(
    parameter int ADDR_W        = 2,
    parameter int DATA_W        = 8,
    parameter int NUM_REGIONS   = 4,
    parameter int USER_PAGE_IDX = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   por_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [2:0]             clr_req,
    input  logic [2:0]             clr_ack,
    output logic [NUM_REGIONS-1:0] flash_mask,
    output logic                   prot_active,
    output logic                   func_en
);
    logic start;
    logic busy;
    logic fin;

    ces_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy_i(busy), .fin_i(fin),
        .start_o(start), .prot_active_o(prot_active), .func_en_o(func_en)
    );

    ces_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .start_i(start),
        .ack_i(clr_ack), .req_o(clr_req), .busy_o(busy), .fin_o(fin)
    );

    ces_flash_mask #(.NUM_REGIONS(NUM_REGIONS), .USER_PAGE_IDX(USER_PAGE_IDX)) u_mask (
        .en_i(clr_req[PH_FLASH]), .mask_o(flash_mask)
    );
endmodule

// File: rtl/chip_erase_seq_chk.sv
// Module: chip_erase_seq_chk
// Checker bound to chip_erase_seq: protocol and state rules over time.
module chip_erase_seq_chk #(
    parameter int ADDR_W        = 2,
    parameter int DATA_W        = 8,
    parameter int NUM_REGIONS   = 4,
    parameter int USER_PAGE_IDX = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   por_n,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [2:0]             clr_req,
    input logic [NUM_REGIONS-1:0] flash_mask,
    input logic                   prot_active,
    input logic                   func_en,
    input logic                   busy,
    input logic                   done
);
    localparam logic [NUM_REGIONS-1:0] KEEP_MASK =
        ~(NUM_REGIONS'(1) << USER_PAGE_IDX);

    a_r2_req_onehot: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $onehot0(clr_req));
    a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (|clr_req) |=> (clr_req == 3'b000));
    a_r3_user_page_kept: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        clr_req[1] |-> (flash_mask == KEEP_MASK));
    a_r3_mask_idle: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !clr_req[1] |-> (flash_mask == '0));
    a_r4_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(done && busy));
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (busy && bus_wr && bus_addr == '0 && bus_wdata[0]) |=> !clr_req[0]);
    a_r6_active_held: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ($past(rst_n) && $past(por_n) && !$past(busy)) |-> $stable(prot_active));
    a_r7_fin_clears: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(done) |-> !prot_active);
    a_r8_no_func_busy: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        busy |-> !func_en);
endmodule

bind chip_erase_seq chip_erase_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_REGIONS(NUM_REGIONS), .USER_PAGE_IDX(USER_PAGE_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .clr_req(clr_req),
    .flash_mask(flash_mask), .prot_active(prot_active), .func_en(func_en),
    .busy(u_fsm.busy_q), .done(u_regs.done_q)
);

// File: tb/chip_erase_seq_tb.sv
// Bench for chip_erase_seq: sweeps acknowledge delays per phase and checks
// protection, reset and ignore rules at the ports.
module chip_erase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int UPG  = 3;
    localparam logic [NREG-1:0] EXP_MASK = ((NREG'(1) << NREG) - 1) & ~(NREG'(1) << UPG);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            por_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [1:0]      bus_addr = 2'd1;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic [2:0]      clr_req;
    logic [2:0]      clr_ack = '0;
    logic [NREG-1:0] flash_mask;
    logic            prot_active;
    logic            func_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    chip_erase_seq #(.NUM_REGIONS(NREG), .USER_PAGE_IDX(UPG)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clr_req(clr_req), .clr_ack(clr_ack), .flash_mask(flash_mask),
        .prot_active(prot_active), .func_en(func_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Bus write lasting one cycle; afterwards the status register is addressed.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd1; bus_wdata = '0;
        #1;
    endtask

    task automatic pulse_rst(input bit por);
        if (por) por_n = 1'b0; else rst_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        #1;
    endtask

    // One phase: request seen now, then wait d cycles, then acknowledge.
    task automatic phase(input int p, input int d, input bit stray);
        check(clr_req == 3'(1 << p), $sformatf("R2 req phase %0d", p), clr_req, 1 << p);
        if (p == 1) check(flash_mask == EXP_MASK, "R3 mask", flash_mask, EXP_MASK);
        else        check(flash_mask == '0, "R3 mask idle", flash_mask, 0);
        if (stray) clr_ack = 3'(1 << p);          // R10 ack during request cycle
        @(negedge clk); #1;
        clr_ack = '0;
        for (int i = 0; i < d; i++) begin
            check(clr_req == 3'b000, "R2 no req while waiting", clr_req, 0);
            check(bus_rdata[0] == 1'b1, "R4 busy while waiting", bus_rdata, 1);
            @(negedge clk); #1;
        end
        if (stray) begin                          // R10 ack at wrong index
            clr_ack = 3'(1 << ((p + 1) % 3));
            @(negedge clk); #1;
            clr_ack = '0;
            check(clr_req == 3'b000, "R10 wrong-index ack ignored", clr_req, 0);
        end
        clr_ack = 3'(1 << p);
        @(negedge clk); #1;
        clr_ack = '0;
    endtask

    task automatic erase(input int d0, input int d1, input int d2, input bit stray);
        bus_write(2'd0, 8'h01);
        check(bus_rdata[1:0] == 2'b01, "R1 busy set, R4 done cleared", bus_rdata[1:0], 1);
        check(func_en == 1'b0, "R8 func_en low", func_en, 0);
        phase(0, d0, stray);
        phase(1, d1, stray);
        phase(2, d2, stray);
        check(bus_rdata == 8'h02, "R4 done, R7 prot cleared", bus_rdata, 2);
        check(prot_active == 1'b0, "R7 prot_active cleared", prot_active, 0);
        check(clr_req == 3'b000, "R2 no req after final", clr_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        #1;
        check(bus_rdata == 8'h00, "R9 status after power-on", bus_rdata, 0);
        check(func_en == 1'b1, "R8 func_en after reset", func_en, 1);
        check(clr_req == 3'b000 && flash_mask == '0, "R3 idle outputs", {clr_req, flash_mask}, 0);

        // R6: arm protection, active only after reset.
        bus_write(2'd0, 8'h02);
        check(bus_rdata == 8'h08, "R6 pending set, active held", bus_rdata, 8'h08);
        check(prot_active == 1'b0, "R6 active unchanged", prot_active, 0);
        repeat (3) @(negedge clk);
        #1;
        check(prot_active == 1'b0, "R6 active still unchanged", prot_active, 0);
        pulse_rst(0);
        check(bus_rdata == 8'h0C, "R6 active after reset", bus_rdata, 8'h0C);
        check(prot_active == 1'b1, "R6 prot_active port", prot_active, 1);
        bus_addr = 2'd0; #1;
        check(bus_rdata == 8'h02, "R5 start bit reads 0, R6 pending readback", bus_rdata, 2);
        bus_addr = 2'd1; #1;

        // Sweep acknowledge delays; first run has stray acks (R10).
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++)
                    erase(a, b, c, (a == 0 && b == 0 && c == 0));

        // R5: start while busy ignored.
        bus_write(2'd0, 8'h01);
        check(clr_req == 3'b001, "R1 req after start", clr_req, 1);
        @(negedge clk); #1;
        bus_write(2'd0, 8'h01);
        check(clr_req == 3'b000, "R5 no extra request", clr_req, 0);
        check(bus_rdata[0] == 1'b1, "R5 still busy", bus_rdata, 1);
        clr_ack = 3'b001; @(negedge clk); #1; clr_ack = '0;
        check(clr_req == 3'b010, "R5 phase continued", clr_req, 2);
        @(negedge clk); #1;
        clr_ack = 3'b010; @(negedge clk); #1; clr_ack = '0;
        check(clr_req == 3'b100, "R2 prot phase", clr_req, 4);
        @(negedge clk); #1;
        clr_ack = 3'b100; @(negedge clk); #1; clr_ack = '0;
        check(bus_rdata == 8'h02, "R4 done", bus_rdata, 2);
        check(func_en == 1'b0, "R8 func_en held low", func_en, 0);

        // R4/R8: reset clears done, restores func_en.
        pulse_rst(0);
        check(bus_rdata == 8'h00, "R4 done cleared by reset", bus_rdata, 0);
        check(func_en == 1'b1, "R8 func_en after restart", func_en, 1);

        // R9: power-on clears active protection.
        bus_write(2'd0, 8'h02);
        pulse_rst(0);
        check(prot_active == 1'b1, "R6 active before power-on", prot_active, 1);
        pulse_rst(1);
        check(bus_rdata == 8'h00, "R9 all clear after power-on", bus_rdata, 0);
        check(prot_active == 1'b0, "R9 prot_active cleared", prot_active, 0);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end
endmodule